// File: doc/BRIEF.md
# Spike-Timing Plasticity Trace Engine

This block applies pair-based spike-timing-dependent plasticity to a square matrix of signed synaptic weights held row-major, with the presynaptic neuron selecting the row and the postsynaptic neuron selecting the column. Every synapse carries a counter-style timing trace, a direction bit that records which end opened the trace, and a static enable bit. A spike from neuron k makes the engine sweep row k, where k is presynaptic, and then column k, where k is postsynaptic. It pairs each synapse with any opposite-direction trace still open, or else opens a fresh trace. A separate time-step tick advances every open trace by one and closes those that reach their window limit.

The learning rule is rectangular. A causal pairing inside the pre window adds a fixed step to the weight. An acausal pairing inside the post window subtracts a fixed step. Anything else leaves the weight as it is. All storage is modelled as internal arrays touched one word per clock, so a spike costs two N-cycle passes and a time step costs one N*N-cycle pass. The engine reports busy for the whole of a pass and accepts work only while idle. Weights and enable bits are written through a load port while idle and read back through a combinational peek port.

Top module: `stdp_trace_engine`

## Requirements
- R1: After reset, busy is low, every weight reads back as zero and every trace is closed, so a lone spike after loading weights changes no weight.
- R2: If neuron p spikes and neuron q (q != p) spikes d time-step ticks later with 1 <= d < tPre, the weight at address p*N+q gains dwPos when its enable bit is 1. For d >= tPre it is unchanged.
- R3: In the same situation, the weight at address q*N+p (q presynaptic, whose postsynaptic partner p fired first) loses dwNeg when 1 <= d < tPost and its enable bit is 1. For d >= tPost it is unchanged.
- R4: Two spikes in the same time step (d = 0) change no weight.
- R5: A pairing closes the synapse's trace, so a second spike of the same postsynaptic neuron that follows it does not apply the step again.
- R6: A synapse whose enable bit is 0 keeps its weight whatever the spike timing.
- R7: Weights are two's complement of width WEIGHT_W, and updates saturate at +127 and -128 for the default width and never wrap.
- R8: The self-synapse of a spiking neuron (address k*N+k) is never paired or altered.
- R9: An accepted spike holds busy high for exactly 2*N cycles and an accepted step for N*N cycles. A spike or step presented while busy is ignored.
- R10: A new spike of a presynaptic neuron restarts its outgoing windows from zero, so pairing is timed from the latest presynaptic spike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one memory word per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| spikeValid | input | 1 | Spike event request, taken only when idle |
| spikeId | input | IW | Index of the spiking neuron |
| stepTick | input | 1 | Time-step request, taken only when idle and no spike is requested |
| tPre | input | TRACE_W | Causal window length in steps |
| tPost | input | TRACE_W | Acausal window length in steps |
| dwPos | input | WEIGHT_W | Unsigned potentiation step |
| dwNeg | input | WEIGHT_W | Unsigned depression step |
| cfgWrEn | input | 1 | Load strobe for one synapse, honoured only when idle |
| cfgAddr | input | AW | Synapse address pre*N+post for loading |
| cfgWeight | input | WEIGHT_W | Signed weight to load |
| cfgEnable | input | 1 | Plasticity enable bit to load |
| peekAddr | input | AW | Synapse address to read back |
| peekWeight | output | WEIGHT_W | Signed weight at peekAddr |
| busy | output | 1 | High while a row, column or step pass runs |

## Verification
A wrong trace or direction bit stays invisible until the next spike of either end of that synapse. It then shows up on the peek port as a weight off by exactly one step, or as an unexpected change on a pair that should be unchanged. The expected weights are therefore compared over the whole matrix after every spike pair, across all ordered neuron pairs and every delay from zero to past both windows. Errors in the pass sequencing show at the busy output within the same pass, as a span that differs from 2*N or N*N cycles.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_ROW,
    OP_COL,
    OP_STEP
  } opKind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_STEP
  } ctrlState_t;

  // Strobes from the sequencer to the storage datapath
  typedef struct packed {
    opKind_t kind;
    logic    skip;
  } memStrobe_t;

endpackage

// File: rtl/stdp_ctrl.sv
module stdp_ctrl
  import stdp_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          spikeValid,
  input  logic [$clog2(N)-1:0]          spikeId,
  input  logic                          stepTick,
  output logic                          busy,
  output memStrobe_t                    strobe,
  output logic [$clog2(N*N)-1:0]        addr
);

  localparam int CELLS = N * N;
  localparam int AW    = $clog2(CELLS);
  localparam int IW    = $clog2(N);
  localparam logic [AW-1:0] LAST_LANE = AW'(N - 1);
  localparam logic [AW-1:0] LAST_CELL = AW'(CELLS - 1);
  localparam logic [AW-1:0] N_A       = AW'(N);

  ctrlState_t     state;
  logic [AW-1:0]  cnt;
  logic [IW-1:0]  neuron;
  logic [AW-1:0]  neuronA;
  logic [AW-1:0]  rowBase;

  assign busy    = (state != ST_IDLE);
  assign neuronA = AW'(neuron);
  assign rowBase = neuronA * N_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      neuron <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (spikeValid) begin
            neuron <= spikeId;
            state  <= ST_ROW;
          end else if (stepTick) begin
            state <= ST_STEP;
          end
        end
        ST_ROW: begin
          if (cnt == LAST_LANE) begin
            cnt   <= '0;
            state <= ST_COL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_COL: begin
          if (cnt == LAST_LANE) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STEP: begin
          if (cnt == LAST_CELL) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.kind = OP_NONE;
    strobe.skip = 1'b0;
    addr        = cnt;
    case (state)
      ST_ROW: begin
        strobe.kind = OP_ROW;
        strobe.skip = (cnt == neuronA);
        addr        = rowBase + cnt;
      end
      ST_COL: begin
        strobe.kind = OP_COL;
        strobe.skip = (cnt == neuronA);
        addr        = cnt * N_A + neuronA;
      end
      ST_STEP: begin
        strobe.kind = OP_STEP;
        addr        = cnt;
      end
      default: ;
    endcase
  end

  // Span counter used only by the checks below
  logic [AW:0] spanCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spanCnt <= '0;
    else        spanCnt <= busy ? spanCnt + 1'b1 : '0;
  end

  AST_ACCEPT_WHEN_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(spikeValid || stepTick)) else $error("busy rose without request"); // R9
  AST_SPAN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (spanCnt < (AW+1)'(CELLS))) else $error("pass overran"); // R9
  AST_NEURON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(neuron)) else $error("neuron changed mid pass"); // R9

endmodule

// File: rtl/stdp_datapath.sv
module stdp_datapath
  import stdp_pkg::*;
#(
  parameter int N        = 4,
  parameter int WEIGHT_W = 8,
  parameter int TRACE_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  memStrobe_t                        strobe,
  input  logic [$clog2(N*N)-1:0]            addr,
  input  logic [TRACE_W-1:0]                tPre,
  input  logic [TRACE_W-1:0]                tPost,
  input  logic [WEIGHT_W-1:0]               dwPos,
  input  logic [WEIGHT_W-1:0]               dwNeg,
  input  logic                              cfgWr,
  input  logic [$clog2(N*N)-1:0]            cfgAddr,
  input  logic signed [WEIGHT_W-1:0]        cfgWeight,
  input  logic                              cfgEnable,
  input  logic [$clog2(N*N)-1:0]            peekAddr,
  output logic signed [WEIGHT_W-1:0]        peekWeight
);

  localparam int CELLS = N * N;
  localparam int AW    = $clog2(CELLS);
  localparam int XW    = WEIGHT_W + 2;
  localparam int MAXV  = 2 ** (WEIGHT_W - 1) - 1;
  localparam int MINV  = -(2 ** (WEIGHT_W - 1));
  localparam logic [TRACE_W-1:0] TRACE_OFF = '1;

  logic signed [WEIGHT_W-1:0] weightMem [CELLS];
  logic [TRACE_W-1:0]         traceMem  [CELLS];
  logic                       pendMem   [CELLS];
  logic                       enMem     [CELLS];

  logic signed [WEIGHT_W-1:0] curW;
  logic [TRACE_W-1:0]         curTrace;
  logic                       curPend;
  logic                       curEn;

  logic opRun, live, aged, depress, potent, paired, expire, writeW;
  logic [TRACE_W-1:0] stepNext, limit, newTrace;
  logic               newPend;
  logic signed [XW-1:0] wExt, upSum, downSum;
  logic signed [WEIGHT_W-1:0] satUp, satDown, newWeight;

  assign curW     = weightMem[addr];
  assign curTrace = traceMem[addr];
  assign curPend  = pendMem[addr];
  assign curEn    = enMem[addr];

  assign peekWeight = weightMem[peekAddr];

  always_comb begin
    opRun    = (strobe.kind != OP_NONE) && !strobe.skip;
    live     = (curTrace != TRACE_OFF);
    aged     = (curTrace != '0);
    depress  = (strobe.kind == OP_ROW) && live && !curPend && aged;
    potent   = (strobe.kind == OP_COL) && live && curPend && aged;
    paired   = depress || potent;
    stepNext = curTrace + TRACE_W'(1);
    limit    = curPend ? tPre : tPost;
    expire   = (stepNext >= limit);

    newTrace = curTrace;
    newPend  = curPend;
    case (strobe.kind)
      OP_ROW: begin
        newTrace = paired ? TRACE_OFF : '0;
        newPend  = !paired;
      end
      OP_COL: begin
        newTrace = paired ? TRACE_OFF : '0;
        newPend  = 1'b0;
      end
      OP_STEP: begin
        if (live && !expire) begin
          newTrace = stepNext;
        end else begin
          newTrace = TRACE_OFF;
          newPend  = 1'b0;
        end
      end
      default: ;
    endcase

    wExt    = XW'(curW);
    upSum   = wExt + $signed({2'b00, dwPos});
    downSum = wExt - $signed({2'b00, dwNeg});
    satUp   = (upSum > MAXV)   ? WEIGHT_W'(MAXV) : upSum[WEIGHT_W-1:0];
    satDown = (downSum < MINV) ? WEIGHT_W'(MINV) : downSum[WEIGHT_W-1:0];
    newWeight = potent ? satUp : satDown;
    writeW    = opRun && paired && curEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) begin
        weightMem[i] <= '0;
        traceMem[i]  <= TRACE_OFF;
        pendMem[i]   <= 1'b0;
        enMem[i]     <= 1'b0;
      end
    end else if (opRun) begin
      traceMem[addr] <= newTrace;
      pendMem[addr]  <= newPend;
      if (writeW) weightMem[addr] <= newWeight;
    end else if (cfgWr) begin
      weightMem[cfgAddr] <= cfgWeight;
      enMem[cfgAddr]     <= cfgEnable;
    end
  end

  // Capture of the word touched last cycle, used only by the checks below
  logic                       chkMask, chkUp, chkDown, chkSkip, chkStep;
  logic [AW-1:0]              chkAddr;
  logic signed [WEIGHT_W-1:0] chkW;
  logic [TRACE_W-1:0]         chkT, chkLimit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chkMask  <= 1'b0;
      chkUp    <= 1'b0;
      chkDown  <= 1'b0;
      chkSkip  <= 1'b0;
      chkStep  <= 1'b0;
      chkAddr  <= '0;
      chkW     <= '0;
      chkT     <= '0;
      chkLimit <= '0;
    end else begin
      chkMask  <= opRun && !curEn;
      chkUp    <= opRun && potent && curEn;
      chkDown  <= opRun && depress && curEn;
      chkSkip  <= (strobe.kind != OP_NONE) && strobe.skip;
      chkStep  <= opRun && (strobe.kind == OP_STEP) && live;
      chkAddr  <= addr;
      chkW     <= curW;
      chkT     <= curTrace;
      chkLimit <= limit;
    end
  end

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    chkMask |-> (weightMem[chkAddr] == chkW)) else $error("masked weight changed"); // R6
  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    chkUp |-> (weightMem[chkAddr] >= chkW)) else $error("potentiation wrapped"); // R7
  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    chkDown |-> (weightMem[chkAddr] <= chkW)) else $error("depression wrapped"); // R7
  AST_SELF_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    chkSkip |-> (weightMem[chkAddr] == chkW && traceMem[chkAddr] == chkT)) else $error("self synapse touched"); // R8
  AST_TRACE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    chkStep |-> (traceMem[chkAddr] == TRACE_OFF || traceMem[chkAddr] < chkLimit)) else $error("trace beyond window"); // R2

endmodule

// File: rtl/stdp_trace_engine.sv
module stdp_trace_engine
  import stdp_pkg::*;
#(
  parameter int N        = 4,
  parameter int WEIGHT_W = 8,
  parameter int TRACE_W  = 8,
  localparam int IW      = $clog2(N),
  localparam int AW      = $clog2(N * N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spikeValid,
  input  logic [IW-1:0]              spikeId,
  input  logic                       stepTick,
  input  logic [TRACE_W-1:0]         tPre,
  input  logic [TRACE_W-1:0]         tPost,
  input  logic [WEIGHT_W-1:0]        dwPos,
  input  logic [WEIGHT_W-1:0]        dwNeg,
  input  logic                       cfgWrEn,
  input  logic [AW-1:0]              cfgAddr,
  input  logic signed [WEIGHT_W-1:0] cfgWeight,
  input  logic                       cfgEnable,
  input  logic [AW-1:0]              peekAddr,
  output logic signed [WEIGHT_W-1:0] peekWeight,
  output logic                       busy
);

  memStrobe_t    strobe;
  logic [AW-1:0] passAddr;
  logic          cfgWr;

  assign cfgWr = cfgWrEn && !busy;

  stdp_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .spikeValid (spikeValid),
    .spikeId    (spikeId),
    .stepTick   (stepTick),
    .busy       (busy),
    .strobe     (strobe),
    .addr       (passAddr)
  );

  stdp_datapath #(.N(N), .WEIGHT_W(WEIGHT_W), .TRACE_W(TRACE_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .addr       (passAddr),
    .tPre       (tPre),
    .tPost      (tPost),
    .dwPos      (dwPos),
    .dwNeg      (dwNeg),
    .cfgWr      (cfgWr),
    .cfgAddr    (cfgAddr),
    .cfgWeight  (cfgWeight),
    .cfgEnable  (cfgEnable),
    .peekAddr   (peekAddr),
    .peekWeight (peekWeight)
  );

endmodule

// File: tb/stdp_trace_engine_test.sv
module stdp_trace_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int CELLS = N * N;
  localparam int IW    = 2;
  localparam int AW    = 4;
  localparam int TPRE  = 4;
  localparam int TPOST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spikeValid = 1'b0;
  logic [IW-1:0] spikeId = '0;
  logic stepTick = 1'b0;
  logic [7:0] tPre = 8'(TPRE);
  logic [7:0] tPost = 8'(TPOST);
  logic [7:0] dwPos = 8'd5;
  logic [7:0] dwNeg = 8'd7;
  logic cfgWrEn = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic signed [7:0] cfgWeight = '0;
  logic cfgEnable = 1'b0;
  logic [AW-1:0] peekAddr = '0;
  logic signed [7:0] peekWeight;
  logic busy;

  int nChecks = 0;
  int nFail = 0;
  int expW [CELLS];
  bit expEn [CELLS];
  int span;

  always #(CLK_PERIOD/2) clk = ~clk;

  stdp_trace_engine uut (
    .clk(clk), .rst_n(rst_n), .spikeValid(spikeValid), .spikeId(spikeId),
    .stepTick(stepTick), .tPre(tPre), .tPost(tPost), .dwPos(dwPos), .dwNeg(dwNeg),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWeight(cfgWeight), .cfgEnable(cfgEnable),
    .peekAddr(peekAddr), .peekWeight(peekWeight), .busy(busy)
  );

  function automatic int sat(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic loadOne(input int idx, input int w, input bit en);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = AW'(idx); cfgWeight = 8'(w); cfgEnable = en;
    @(negedge clk);
    cfgWrEn = 1'b0;
    expW[idx] = w; expEn[idx] = en;
  endtask

  task automatic loadAll(input int c, input bit allOn);
    @(negedge clk);
    for (int i = 0; i < CELLS; i++) begin
      expW[i]  = ((i * 37 + c * 11) % 256) - 128;
      expEn[i] = allOn ? 1'b1 : (((i + c) % 4) != 0);
      cfgWrEn = 1'b1; cfgAddr = AW'(i); cfgWeight = 8'(expW[i]); cfgEnable = expEn[i];
      @(negedge clk);
    end
    cfgWrEn = 1'b0;
  endtask

  task automatic fireSpike(input int k, output int cycles);
    @(negedge clk);
    spikeValid = 1'b1; spikeId = IW'(k);
    @(negedge clk);
    spikeValid = 1'b0;
    cycles = 0;
    while (busy) begin cycles++; @(negedge clk); end
  endtask

  task automatic advance(output int cycles);
    @(negedge clk);
    stepTick = 1'b1;
    @(negedge clk);
    stepTick = 1'b0;
    cycles = 0;
    while (busy) begin cycles++; @(negedge clk); end
  endtask

  task automatic steps(input int n);
    int c;
    for (int i = 0; i < n; i++) advance(c);
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < CELLS; i++) begin
      peekAddr = AW'(i);
      #1;
      chk(int'(peekWeight) == expW[i], req, int'(peekWeight), expW[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int ia, ib, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    for (int i = 0; i < CELLS; i++) expW[i] = 0;
    checkAll("R1 weights after reset");
    loadAll(104, 1'b1);
    fireSpike(2, span);
    checkAll("R1 lone spike with closed traces");
    steps(4);

    // R9: pass lengths
    fireSpike(1, span);
    chk(span == 2 * N, "R9 spike busy span", span, 2 * N);
    advance(span);
    chk(span == CELLS, "R9 step busy span", span, CELLS);
    steps(4);

    // Sweep over ordered pairs and delays: R2 R3 R4 R6 R8
    c = 0;
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        if (a == b) continue;
        for (int d = 0; d <= 5; d++) begin
          loadAll(c, 1'b0);
          fireSpike(a, span);
          steps(d);
          fireSpike(b, span);
          ia = a * N + b;
          ib = b * N + a;
          if (d >= 1 && d < TPRE && expEn[ia])  expW[ia] = sat(expW[ia] + 5);
          if (d >= 1 && d < TPOST && expEn[ib]) expW[ib] = sat(expW[ib] - 7);
          checkAll("R2/R3/R4/R6/R8 sweep");
          steps(4);
          c++;
        end
      end
    end

    // R5: pairing consumes the trace
    loadAll(100, 1'b1);
    fireSpike(1, span);
    steps(2);
    fireSpike(2, span);
    expW[1*N+2] = sat(expW[1*N+2] + 5);
    expW[2*N+1] = sat(expW[2*N+1] - 7);
    steps(1);
    fireSpike(2, span);
    checkAll("R5 second post spike");
    steps(4);

    // R10: a repeated presynaptic spike restarts the window
    loadAll(101, 1'b1);
    fireSpike(0, span);
    steps(3);
    fireSpike(0, span);
    steps(2);
    fireSpike(3, span);
    expW[0*N+3] = sat(expW[0*N+3] + 5);
    expW[3*N+0] = sat(expW[3*N+0] - 7);
    checkAll("R10 restarted window");
    steps(4);

    // R7: saturation at both ends
    loadAll(102, 1'b1);
    loadOne(1*N+3, 125, 1'b1);
    loadOne(3*N+1, -125, 1'b1);
    fireSpike(1, span);
    steps(1);
    fireSpike(3, span);
    expW[1*N+3] = 127;
    expW[3*N+1] = -128;
    checkAll("R7 saturation small steps");
    steps(4);
    dwPos = 8'd200; dwNeg = 8'd250;
    loadOne(2*N+0, 0, 1'b1);
    loadOne(0*N+2, 0, 1'b1);
    fireSpike(2, span);
    steps(1);
    fireSpike(0, span);
    expW[2*N+0] = 127;
    expW[0*N+2] = -128;
    checkAll("R7 saturation large steps");
    steps(4);
    dwPos = 8'd5; dwNeg = 8'd7;

    // R8: a neuron firing twice never pairs with itself
    loadAll(103, 1'b1);
    fireSpike(2, span);
    steps(1);
    fireSpike(2, span);
    checkAll("R8 repeated self spike");
    steps(4);

    // R9: spike offered during a step pass is ignored
    loadAll(105, 1'b1);
    fireSpike(0, span);
    steps(1);
    @(negedge clk);
    stepTick = 1'b1;
    @(negedge clk);
    stepTick = 1'b0;
    spikeValid = 1'b1; spikeId = IW'(1);
    @(negedge clk);
    spikeValid = 1'b0;
    chk(busy == 1'b1, "R9 busy during step pass", int'(busy), 1);
    while (busy) @(negedge clk);
    steps(4);
    checkAll("R9 spike while busy ignored");

    summary();
    $finish;
  end

endmodule